// File: doc/BRIEF.md
# Edge-Latching Input Capture Unit

This block watches a set of external input pins and records when each one changes level. It does this by snapshotting a free-running 16-bit down-counter that is supplied from outside. Every channel is handled independently. The raw pin first passes through a two-stage synchronizer. The synchronized level can then be forced low by a gate, and optionally inverted. What remains is compared with its value one cycle earlier.

A low-to-high change of this conditioned signal copies the counter into the channel's rising snapshot register and raises a rising indicator. A high-to-low change does the same into a separate falling snapshot register with its own indicator. Each edge direction has its own interrupt enable, and both feed one per-channel interrupt flag.

Software clears the status through a per-channel write strobe that carries a 3-bit data word. The interrupt flag clears when a 1 is written to it. The level that clears an indicator is chosen by a shared polarity bit, so that firmware written for either convention works unchanged.

Top module: `edge_capture_unit`

## Requirements
- R1: A level change on a pin shows in that channel's indicator and snapshot register exactly three rising clock edges after the pin changes: two synchronizer stages plus the output register.
- R2: With `in_invert` set, the conditioned input is the inverse of the synchronized pin. A falling pin is then reported as a rising event, and the reverse.
- R3: With `gate_en` low, the conditioned input is constant 0 whatever the pin or `in_invert` does. Toggling the pin then changes no indicator, snapshot or flag.
- R4: A rising event loads `count_in` into that channel's slice of `rise_val` and sets `rise_seen`. `fall_val` and `fall_seen` are left untouched.
- R5: A falling event loads `count_in` into `fall_val` and sets `fall_seen`. `rise_val` and `rise_seen` are left untouched.
- R6: With `cap_en` low, edges update neither snapshot register, set no indicator and do not raise `cap_flag`.
- R7: `cap_flag` is set by a rising event when `rise_ie` is high and by a falling event when `fall_ie` is high. It is cleared by a status write with `stat_wdata` bit 0 at 1. Writing 0 there leaves it set.
- R8: A status write clears `rise_seen` when `stat_wdata` bit 1 equals `clr_pol`, and clears `fall_seen` when bit 2 equals `clr_pol`. Writing the other level leaves the indicator set.
- R9: When a capture event and a clearing status write reach a channel in the same cycle, the indicator and the flag end up set.
- R10: After synchronous reset, every snapshot register, indicator and flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NCH | Raw asynchronous input pins |
| count_in | input | CNT_W | Current value of the external down-counter |
| in_invert | input | NCH | Per channel: invert the synchronized input |
| gate_en | input | NCH | Per channel: pass the input (0 forces it low) |
| cap_en | input | NCH | Per channel: allow snapshots, indicators and the flag |
| rise_ie | input | NCH | Per channel: rising events raise the flag |
| fall_ie | input | NCH | Per channel: falling events raise the flag |
| clr_pol | input | 1 | Level that clears indicators on a status write |
| stat_wr | input | NCH | Per channel status write strobe |
| stat_wdata | input | 3 | Status write data: bit0 flag, bit1 rising indicator, bit2 falling indicator |
| rise_val | output | NCH*CNT_W | Rising snapshot registers, channel c at [c*CNT_W +: CNT_W] |
| fall_val | output | NCH*CNT_W | Falling snapshot registers, same layout |
| rise_seen | output | NCH | Rising indicators |
| fall_seen | output | NCH | Falling indicators |
| cap_flag | output | NCH | Per channel interrupt flag |

## Verification
The main sweep runs a rising and then a falling pin transition on every channel. It covers both inverter settings and all four combinations of interrupt enables. Each event uses a different counter value, so a swapped snapshot register, a wrong channel slice or a stale capture shows up as a wrong number. A stepwise latency probe tells a three-edge pipeline apart from one that is a cycle shorter or longer.

Further patterns toggle the pin with the gate closed, and again with capture disabled, to confirm that nothing updates. A status-write sweep covers both clear polarities against both written levels. A write timed onto the capture cycle shows whether the set wins over the clear.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int unsigned ST_W        = 3;
  localparam int unsigned ST_FLAG_BIT = 0;
  localparam int unsigned ST_RISE_BIT = 1;
  localparam int unsigned ST_FALL_BIT = 2;

  typedef struct packed {
    logic invert;
    logic gate;
    logic cap_en;
    logic rise_ie;
    logic fall_ie;
  } ch_cfg_t;
endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ecu_edge_detect.sv
module ecu_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_sync,
  input  logic gate,
  input  logic invert,
  output logic rise_ev,
  output logic fall_ev
);
  logic cond;
  logic cond_q;

  // gate forces 0 first, inversion only applies to a passed level
  assign cond = gate ? (level_sync ^ invert) : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= cond;
  end

  assign rise_ev = cond & ~cond_q;
  assign fall_ev = ~cond & cond_q;
endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
  import ecu_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ch_cfg_t          cfg,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic [CNT_W-1:0] count_in,
  input  logic             clr_pol,
  input  logic             stat_wr,
  input  logic [ST_W-1:0]  stat_wdata,
  output logic [CNT_W-1:0] rise_val,
  output logic [CNT_W-1:0] fall_val,
  output logic             rise_seen,
  output logic             fall_seen,
  output logic             cap_flag
);
  logic take_rise, take_fall, flag_set;
  logic clr_rise, clr_fall, clr_flag;

  assign take_rise = cfg.cap_en & rise_ev;
  assign take_fall = cfg.cap_en & fall_ev;
  assign flag_set  = (take_rise & cfg.rise_ie) | (take_fall & cfg.fall_ie);
  assign clr_rise  = stat_wr & (stat_wdata[ST_RISE_BIT] == clr_pol);
  assign clr_fall  = stat_wr & (stat_wdata[ST_FALL_BIT] == clr_pol);
  assign clr_flag  = stat_wr & stat_wdata[ST_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_val  <= '0;
      fall_val  <= '0;
      rise_seen <= 1'b0;
      fall_seen <= 1'b0;
      cap_flag  <= 1'b0;
    end else begin
      if (take_rise) rise_val <= count_in;
      if (take_fall) fall_val <= count_in;

      if (take_rise)     rise_seen <= 1'b1;
      else if (clr_rise) rise_seen <= 1'b0;

      if (take_fall)     fall_seen <= 1'b1;
      else if (clr_fall) fall_seen <= 1'b0;

      if (flag_set)      cap_flag <= 1'b1;
      else if (clr_flag) cap_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       pin_in,
  input  logic [CNT_W-1:0]     count_in,
  input  logic [NCH-1:0]       in_invert,
  input  logic [NCH-1:0]       gate_en,
  input  logic [NCH-1:0]       cap_en,
  input  logic [NCH-1:0]       rise_ie,
  input  logic [NCH-1:0]       fall_ie,
  input  logic                 clr_pol,
  input  logic [NCH-1:0]       stat_wr,
  input  logic [ST_W-1:0]      stat_wdata,
  output logic [NCH*CNT_W-1:0] rise_val,
  output logic [NCH*CNT_W-1:0] fall_val,
  output logic [NCH-1:0]       rise_seen,
  output logic [NCH-1:0]       fall_seen,
  output logic [NCH-1:0]       cap_flag
);
  logic [NCH-1:0] pin_sync;
  logic [NCH-1:0] rise_ev;
  logic [NCH-1:0] fall_ev;

  ecu_sync #(.STAGES(SYNC_STAGES), .W(NCH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_cfg_t cfg;
    assign cfg.invert  = in_invert[c];
    assign cfg.gate    = gate_en[c];
    assign cfg.cap_en  = cap_en[c];
    assign cfg.rise_ie = rise_ie[c];
    assign cfg.fall_ie = fall_ie[c];

    ecu_edge_detect u_edge (
      .clk        (clk),
      .rst        (rst),
      .level_sync (pin_sync[c]),
      .gate       (cfg.gate),
      .invert     (cfg.invert),
      .rise_ev    (rise_ev[c]),
      .fall_ev    (fall_ev[c])
    );

    ecu_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .cfg        (cfg),
      .rise_ev    (rise_ev[c]),
      .fall_ev    (fall_ev[c]),
      .count_in   (count_in),
      .clr_pol    (clr_pol),
      .stat_wr    (stat_wr[c]),
      .stat_wdata (stat_wdata),
      .rise_val   (rise_val[c*CNT_W +: CNT_W]),
      .fall_val   (fall_val[c*CNT_W +: CNT_W]),
      .rise_seen  (rise_seen[c]),
      .fall_seen  (fall_seen[c]),
      .cap_flag   (cap_flag[c])
    );
  end
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker
  import ecu_pkg::*;
#(
  parameter int unsigned NCH   = 2,
  parameter int unsigned CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH-1:0]       cap_en,
  input logic [NCH-1:0]       rise_ie,
  input logic [NCH-1:0]       fall_ie,
  input logic                 clr_pol,
  input logic [NCH-1:0]       stat_wr,
  input logic [ST_W-1:0]      stat_wdata,
  input logic [NCH-1:0]       rise_ev,
  input logic [NCH-1:0]       fall_ev,
  input logic [NCH*CNT_W-1:0] rise_val,
  input logic [NCH*CNT_W-1:0] fall_val,
  input logic [NCH-1:0]       rise_seen,
  input logic [NCH-1:0]       fall_seen,
  input logic [NCH-1:0]       cap_flag
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_rise_latch_gated_r6: assert property (@(posedge clk) disable iff (rst)
      !$stable(rise_val[c*CNT_W +: CNT_W]) |-> $past(cap_en[c] && rise_ev[c]));

    p_fall_latch_gated_r6: assert property (@(posedge clk) disable iff (rst)
      !$stable(fall_val[c*CNT_W +: CNT_W]) |-> $past(cap_en[c] && fall_ev[c]));

    p_flag_cause_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_flag[c]) |->
        $past(cap_en[c] && ((rise_ev[c] && rise_ie[c]) || (fall_ev[c] && fall_ie[c]))));

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
      $past(stat_wr[c] && stat_wdata[ST_FLAG_BIT] &&
            !(cap_en[c] && ((rise_ev[c] && rise_ie[c]) || (fall_ev[c] && fall_ie[c]))))
        |-> !cap_flag[c]);

    p_rise_clear_r8: assert property (@(posedge clk) disable iff (rst)
      $past(stat_wr[c] && (stat_wdata[ST_RISE_BIT] == clr_pol) && !(cap_en[c] && rise_ev[c]))
        |-> !rise_seen[c]);

    p_rise_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
      $past(cap_en[c] && rise_ev[c]) |-> rise_seen[c]);

    p_fall_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
      $past(cap_en[c] && fall_ev[c]) |-> fall_seen[c]);
  end
endmodule

bind edge_capture_unit ecu_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_ecu_checker (
  .clk        (clk),
  .rst        (rst),
  .cap_en     (cap_en),
  .rise_ie    (rise_ie),
  .fall_ie    (fall_ie),
  .clr_pol    (clr_pol),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .rise_ev    (rise_ev),
  .fall_ev    (fall_ev),
  .rise_val   (rise_val),
  .fall_val   (fall_val),
  .rise_seen  (rise_seen),
  .fall_seen  (fall_seen),
  .cap_flag   (cap_flag)
);

// File: tb/edge_capture_unit_bench.sv
module edge_capture_unit_bench;
  localparam int NCH    = 2;
  localparam int CNT_W  = 16;
  localparam int CLK_NS = 10;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NCH-1:0]       pin_in = '0;
  logic [CNT_W-1:0]     count_in = '0;
  logic [NCH-1:0]       in_invert = '0;
  logic [NCH-1:0]       gate_en = '0;
  logic [NCH-1:0]       cap_en = '0;
  logic [NCH-1:0]       rise_ie = '0;
  logic [NCH-1:0]       fall_ie = '0;
  logic                 clr_pol = 1'b0;
  logic [NCH-1:0]       stat_wr = '0;
  logic [2:0]           stat_wdata = '0;
  logic [NCH*CNT_W-1:0] rise_val;
  logic [NCH*CNT_W-1:0] fall_val;
  logic [NCH-1:0]       rise_seen;
  logic [NCH-1:0]       fall_seen;
  logic [NCH-1:0]       cap_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  edge_capture_unit #(.NCH(NCH), .CNT_W(CNT_W)) u_edge_capture_unit (
    .clk(clk), .rst(rst), .pin_in(pin_in), .count_in(count_in),
    .in_invert(in_invert), .gate_en(gate_en), .cap_en(cap_en),
    .rise_ie(rise_ie), .fall_ie(fall_ie), .clr_pol(clr_pol),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .rise_val(rise_val), .fall_val(fall_val),
    .rise_seen(rise_seen), .fall_seen(fall_seen), .cap_flag(cap_flag)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // status write that clears flag and both indicators under the current polarity
  task automatic clear_all(int ch);
    stat_wr[ch] = 1'b1;
    stat_wdata  = {clr_pol, clr_pol, 1'b1};
    step(1);
    stat_wr     = '0;
    stat_wdata  = '0;
  endtask

  function automatic logic [CNT_W-1:0] rv(int ch);
    return rise_val[ch*CNT_W +: CNT_W];
  endfunction
  function automatic logic [CNT_W-1:0] fv(int ch);
    return fall_val[ch*CNT_W +: CNT_W];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R10 reset state
    chk("R10 rise_val", rise_val, 0);
    chk("R10 fall_val", fall_val, 0);
    chk("R10 indicators", {rise_seen, fall_seen}, 0);
    chk("R10 cap_flag", cap_flag, 0);

    // R1 latency probe on channel 0
    gate_en = '1; cap_en = '1;
    step(4);
    count_in = 16'hBEEF;
    pin_in[0] = 1'b1;
    step(2);
    chk("R1 not yet after two edges", rise_seen[0], 0);
    step(1);
    chk("R1 set after three edges", rise_seen[0], 1);
    chk("R1 value", rv(0), 16'hBEEF);
    pin_in[0] = 1'b0;
    step(4);
    clear_all(0);

    // main sweep: channel x inverter x interrupt enables
    for (int ch = 0; ch < NCH; ch++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int ie = 0; ie < 4; ie++) begin
          logic [CNT_W-1:0] cr;
          logic [CNT_W-1:0] cf;
          logic [CNT_W-1:0] r_before;
          logic [CNT_W-1:0] f_before;
          cr = CNT_W'(16'h1000 + ch*256 + inv*16 + ie);
          cf = ~cr;
          in_invert[ch] = inv[0];
          rise_ie[ch]   = ie[0];
          fall_ie[ch]   = ie[1];
          pin_in[ch]    = inv[0];        // conditioned level 0
          step(5);
          clear_all(ch);
          f_before = fv(ch);
          count_in = cr;
          pin_in[ch] = ~inv[0];          // conditioned rises (R2 when inverted)
          step(3);
          chk("R4 R2 rise_seen", rise_seen[ch], 1);
          chk("R4 R2 rise_val", rv(ch), cr);
          chk("R4 fall_seen untouched", fall_seen[ch], 0);
          chk("R4 fall_val untouched", fv(ch), f_before);
          chk("R7 flag from rising", cap_flag[ch], ie[0]);
          clear_all(ch);
          chk("R7 flag cleared", cap_flag[ch], 0);
          r_before = rv(ch);
          count_in = cf;
          pin_in[ch] = inv[0];           // conditioned falls
          step(3);
          chk("R5 R2 fall_seen", fall_seen[ch], 1);
          chk("R5 R2 fall_val", fv(ch), cf);
          chk("R5 rise_seen untouched", rise_seen[ch], 0);
          chk("R5 rise_val untouched", rv(ch), r_before);
          chk("R7 flag from falling", cap_flag[ch], ie[1]);
          clear_all(ch);
        end
      end
    end
    in_invert = '0; rise_ie = '1; fall_ie = '1;
    pin_in = '0;
    step(5);
    clear_all(0); clear_all(1);

    // R3 gate closed: pin toggles change nothing
    gate_en[1] = 1'b0;
    step(5);
    clear_all(1);
    begin
      logic [CNT_W-1:0] r0, f0;
      r0 = rv(1); f0 = fv(1);
      count_in = 16'h5A5A;
      for (int k = 0; k < 4; k++) begin
        pin_in[1] = ~pin_in[1];
        step(4);
      end
      in_invert[1] = 1'b1;
      step(4);
      chk("R3 gated rise_seen", rise_seen[1], 0);
      chk("R3 gated fall_seen", fall_seen[1], 0);
      chk("R3 gated flag", cap_flag[1], 0);
      chk("R3 gated values", {rv(1), fv(1)}, {r0, f0});
    end
    in_invert[1] = 1'b0; gate_en[1] = 1'b1;
    step(5);
    clear_all(1);

    // R6 capture disabled
    cap_en[0] = 1'b0;
    begin
      logic [CNT_W-1:0] r0, f0;
      r0 = rv(0); f0 = fv(0);
      count_in = 16'h7777;
      pin_in[0] = 1'b1; step(4);
      pin_in[0] = 1'b0; step(4);
      chk("R6 no indicators", {rise_seen[0], fall_seen[0]}, 0);
      chk("R6 no flag", cap_flag[0], 0);
      chk("R6 values frozen", {rv(0), fv(0)}, {r0, f0});
    end
    cap_en[0] = 1'b1;

    // R7 flag write of 0 does not clear; R8 polarity sweep
    for (int pol = 0; pol < 2; pol++) begin
      clr_pol = pol[0];
      count_in = 16'h0100 + 16'(pol);
      pin_in[0] = 1'b1; step(4);
      pin_in[0] = 1'b0; step(4);
      chk("R8 both set", {rise_seen[0], fall_seen[0]}, 2'b11);
      stat_wr[0] = 1'b1;
      stat_wdata = {~pol[0], ~pol[0], 1'b0};
      step(1);
      stat_wr = '0;
      chk("R8 opposite level keeps indicators", {rise_seen[0], fall_seen[0]}, 2'b11);
      chk("R7 flag write 0 keeps flag", cap_flag[0], 1);
      stat_wr[0] = 1'b1;
      stat_wdata = {~pol[0], pol[0], 1'b0};
      step(1);
      stat_wr = '0;
      chk("R8 rise cleared alone", {rise_seen[0], fall_seen[0]}, 2'b01);
      stat_wr[0] = 1'b1;
      stat_wdata = {pol[0], ~pol[0], 1'b0};
      step(1);
      stat_wr = '0;
      chk("R8 fall cleared", fall_seen[0], 0);
      clear_all(0);
    end

    // R9 set beats a same-cycle clear
    clr_pol = 1'b1;
    count_in = 16'hC0DE;
    pin_in[0] = 1'b1;
    step(2);
    stat_wr[0] = 1'b1;
    stat_wdata = 3'b111;
    step(1);
    stat_wr = '0;
    chk("R9 rise_seen wins", rise_seen[0], 1);
    chk("R9 flag wins", cap_flag[0], 1);
    chk("R9 value", rv(0), 16'hC0DE);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule